// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a windowed watchdog with a 32-bit mode and status register on a plain register bus (address, write strobe, write data, registered read data). A down counter is loaded from a programmable time-out constant by a two-write feed sequence. Software must feed it neither too late (the counter expires) nor too early (the counter is still above a window value). It must also write the two feed bytes back to back. A warning flag is raised as the counter passes a programmable threshold. A time-out raises either an interrupt or a one-cycle reset request, depending on a sticky mode bit.

The mode bits are one-way. The enable cannot be withdrawn once running. Reset-enable, protect and lock can only be set, and reset clears them. The time-out flag and the warning flag clear with opposite write polarities. A protect mode only allows reloads of the time-out constant once the counter is low. A lock mode, once armed by a feed, refuses a clock-off request from the system.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the mode register reads 0, the counter and the time-out constant read 255, the threshold reads 0, the window reads all ones (0xFFFFFF), and both the interrupt and the reset request are low.
- R2: The mode register is at address 0. Bit 0 enables, bit 1 selects reset on time-out, bit 2 is the time-out flag, bit 3 is the warning flag, bit 4 is protect and bit 5 is lock. The other registers are: time-out constant at 1, feed at 2, counter (read only) at 3, warning threshold (10 bits) at 4, window at 5. Read data appears one cycle after the address is presented. Setting the enable does not start the counter. The counter starts on the first valid feed with enable set. From then on it decrements by one per cycle and cannot be stopped; writing 0 to bit 0 has no effect.
- R3: A valid feed is a write of 0xAA to the feed register followed directly by a write of 0x55 to it, and it reloads the counter from the time-out constant. Any other write directly after 0xAA is a feed error: it sets the time-out flag and does not reload.
- R4: A valid feed completed while the running counter is above the window value is a feed error: it sets the time-out flag and the counter keeps decrementing.
- R5: When the running counter steps from 1 to 0 the time-out flag is set and the counter stays at 0.
- R6: Writing 0 to bit 2 clears the time-out flag; writing 1 leaves it unchanged.
- R7: The warning flag is set when the running counter equals the threshold and stays set until software writes 1 to bit 3; writing 0 to bit 3 has no effect.
- R8: A write of 1 to bit 3 does not clear the warning flag while the threshold equals the counter value.
- R9: Bit 1, once set, cannot be cleared. With bit 1 set, each time-out event produces exactly one one-cycle reset request and the interrupt ignores the time-out flag. With bit 1 clear, the interrupt is the warning flag OR the time-out flag.
- R10: Bit 4 can only be set. While it is set, a write to the time-out constant takes effect only if the counter is below both the threshold and the window. Otherwise the constant is kept and the time-out flag is set.
- R11: Bit 5 can only be set. Until a valid feed follows it, the clock-off grant follows the clock-off request one cycle later. After the feed the grant is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| clk_off_req_i | input | 1 | Request to stop the watchdog clock |
| clk_off_grant_o | output | 1 | Grant of the clock-off request |
| irq_o | output | 1 | Interrupt |
| sys_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Several pairs of functions can fall in the same cycle. The case chosen here is the counter reaching the warning threshold together with a software clear of the warning flag. With a zero threshold and an interrupt-only time-out, the stopped counter at 0 keeps the threshold match alive. A clear written there must leave the flag set. The bench then moves the threshold away and shows that the same write now clears the flag. Randomly chosen time-out constants, thresholds and idle lengths sweep the read sample across the threshold crossing. Each read is judged against a cycle-exact count computed in the bench, and the flag and interrupt are judged one cycle apart.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [2:0] A_MODE   = 3'h0;
  localparam logic [2:0] A_RELOAD = 3'h1;
  localparam logic [2:0] A_FEED   = 3'h2;
  localparam logic [2:0] A_COUNT  = 3'h3;
  localparam logic [2:0] A_WARN   = 3'h4;
  localparam logic [2:0] A_WINDOW = 3'h5;

  localparam logic [7:0] FEED_FIRST  = 8'hAA;
  localparam logic [7:0] FEED_SECOND = 8'h55;

  // packed so that each field sits at its register bit position
  typedef struct packed {
    logic lock;    // bit 5
    logic prot;    // bit 4
    logic wint;    // bit 3
    logic tof;     // bit 2
    logic rsten;   // bit 1
    logic en;      // bit 0
  } mode_t;
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_feed,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              feed_ok,
  output logic              seq_err
);
  import wdt_pkg::*;

  logic armed_q;

  always_comb begin
    feed_ok = wr_en && armed_q && wr_feed && (wr_byte == BYTE_W'(FEED_SECOND));
    seq_err = wr_en && armed_q && !feed_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (wr_en) begin
      armed_q <= !armed_q && wr_feed && (wr_byte == BYTE_W'(FEED_FIRST));
    end
  end

  // any write after the first byte ends the sequence (R3)
  assert_seq_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && armed_q) |=> !armed_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] CNT_RST = CNT_W'(255)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             feed_ok,
  input  logic             enable,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] window,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             expire,
  output logic             win_err
);
  logic load;

  always_comb begin
    win_err = feed_ok && run_q && (count_q > window);
    load    = feed_ok && !win_err;
    expire  = run_q && !load && (count_q == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= CNT_RST;
      run_q   <= 1'b0;
    end else begin
      if (load) begin
        count_q <= reload_val;
        if (enable) run_q <= 1'b1;
      end else if (run_q && count_q != '0) begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assert_run_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !feed_ok) |=> $stable(count_q));
  assert_decrement_R2: assert property (@(posedge clk) disable iff (rst)
    (run_q && !feed_ok && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));
  assert_window_noreload_R4: assert property (@(posedge clk) disable iff (rst)
    win_err |=> (count_q == $past(count_q) - CNT_W'(1)));
endmodule

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_we,
  input  wdt_pkg::mode_t wr_mode,
  input  logic          tof_evt,
  input  logic          warn_evt,
  input  logic          warn_eq,
  input  logic          feed_ok,
  input  logic          clk_req,
  output wdt_pkg::mode_t mode_q,
  output logic          irq_q,
  output logic          rst_req_q,
  output logic          grant_q
);
  import wdt_pkg::*;

  mode_t mode_n;
  logic  lock_act_q, lock_act_n;

  always_comb begin
    mode_n       = mode_q;
    mode_n.en    = mode_q.en    | (mode_we & wr_mode.en);
    mode_n.rsten = mode_q.rsten | (mode_we & wr_mode.rsten);
    mode_n.prot  = mode_q.prot  | (mode_we & wr_mode.prot);
    mode_n.lock  = mode_q.lock  | (mode_we & wr_mode.lock);
    mode_n.tof   = tof_evt  | (mode_q.tof  & ~(mode_we & ~wr_mode.tof));
    mode_n.wint  = warn_evt | (mode_q.wint & ~(mode_we & wr_mode.wint & ~warn_eq));
    lock_act_n   = lock_act_q | (mode_q.lock & feed_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      lock_act_q <= 1'b0;
      irq_q      <= 1'b0;
      rst_req_q  <= 1'b0;
      grant_q    <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      lock_act_q <= lock_act_n;
      irq_q      <= mode_n.wint | (mode_n.tof & ~mode_n.rsten);
      rst_req_q  <= tof_evt & mode_q.rsten;
      grant_q    <= clk_req & ~lock_act_n;
    end
  end

  assert_rsten_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    mode_q.rsten |=> mode_q.rsten);
  assert_rst_has_flag_R9: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |-> mode_q.tof);
  assert_flag_on_event_R5: assert property (@(posedge clk) disable iff (rst)
    tof_evt |=> mode_q.tof);
  assert_warn_clear_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q.wint && mode_we && wr_mode.wint && warn_eq) |=> mode_q.wint);
  assert_prot_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    mode_q.prot |=> mode_q.prot);
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    mode_q.lock |=> mode_q.lock);
  assert_lock_grant_R11: assert property (@(posedge clk) disable iff (rst)
    lock_act_q |-> !grant_q);
endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int WARN_W = 10,
  parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(255)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              clk_off_req_i,
  output logic              clk_off_grant_o,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] WIN_RST = '1;
  localparam int MODE_W = $bits(mode_t);

  logic [CNT_W-1:0]  reload_q, win_q, count_q, warn_ext;
  logic [WARN_W-1:0] warn_q;
  logic              wr_mode, wr_reload, wr_feed_sel, wr_warn, wr_win;
  logic              feed_ok, seq_err, run_q, expire, win_err;
  logic              reload_ok, prot_err, tof_evt, warn_evt, warn_eq;
  mode_t             mode_q;

  always_comb begin
    wr_mode     = bus_we && (bus_addr == ADDR_W'(A_MODE));
    wr_reload   = bus_we && (bus_addr == ADDR_W'(A_RELOAD));
    wr_feed_sel = (bus_addr == ADDR_W'(A_FEED));
    wr_warn     = bus_we && (bus_addr == ADDR_W'(A_WARN));
    wr_win      = bus_we && (bus_addr == ADDR_W'(A_WINDOW));
    warn_ext    = CNT_W'(warn_q);
    reload_ok   = !mode_q.prot || ((count_q < warn_ext) && (count_q < win_q));
    prot_err    = wr_reload && !reload_ok;
    tof_evt     = expire | seq_err | win_err | prot_err;
    warn_eq     = (count_q == warn_ext);
    warn_evt    = run_q && warn_eq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= RELOAD_RST;
      warn_q   <= '0;
      win_q    <= WIN_RST;
    end else begin
      if (wr_reload && reload_ok) reload_q <= bus_wdata[CNT_W-1:0];
      if (wr_warn)                warn_q   <= bus_wdata[WARN_W-1:0];
      if (wr_win)                 win_q    <= bus_wdata[CNT_W-1:0];
    end
  end

  wdt_feed_seq #(.BYTE_W(8)) u_feed (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bus_we),
    .wr_feed (wr_feed_sel),
    .wr_byte (bus_wdata[7:0]),
    .feed_ok (feed_ok),
    .seq_err (seq_err)
  );

  wdt_counter #(.CNT_W(CNT_W), .CNT_RST(RELOAD_RST)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .feed_ok    (feed_ok),
    .enable     (mode_q.en),
    .reload_val (reload_q),
    .window     (win_q),
    .count_q    (count_q),
    .run_q      (run_q),
    .expire     (expire),
    .win_err    (win_err)
  );

  wdt_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .mode_we   (wr_mode),
    .wr_mode   (mode_t'(bus_wdata[MODE_W-1:0])),
    .tof_evt   (tof_evt),
    .warn_evt  (warn_evt),
    .warn_eq   (warn_eq),
    .feed_ok   (feed_ok),
    .clk_req   (clk_off_req_i),
    .mode_q    (mode_q),
    .irq_q     (irq_o),
    .rst_req_q (sys_rst_req_o),
    .grant_q   (clk_off_grant_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(A_MODE):   bus_rdata <= DATA_W'(mode_q);
        ADDR_W'(A_RELOAD): bus_rdata <= DATA_W'(reload_q);
        ADDR_W'(A_COUNT):  bus_rdata <= DATA_W'(count_q);
        ADDR_W'(A_WARN):   bus_rdata <= DATA_W'(warn_q);
        ADDR_W'(A_WINDOW): bus_rdata <= DATA_W'(win_q);
        default:           bus_rdata <= '0;
      endcase
    end
  end

  assert_protect_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_reload && mode_q.prot && (count_q >= warn_ext)) |=> $stable(reload_q));
endmodule

// File: tb/tb_windowed_watchdog.sv
module tb_windowed_watchdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        clk_off_req_i = 1'b0;
  logic        clk_off_grant_o, irq_o, sys_rst_req_o;

  int checks = 0;
  int fails = 0;
  int rst_pulses = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  windowed_watchdog dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_off_req_i(clk_off_req_i), .clk_off_grant_o(clk_off_grant_o),
    .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
  );

  always @(negedge clk) if (!rst && sys_rst_req_o) rst_pulses++;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic feed();
    wr(3'h2, 32'hAA);
    wr(3'h2, 32'h55);
  endtask

  task automatic do_reset();
    rst = 1'b1; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rst_pulses = 0;
    @(negedge clk);
  endtask

  function automatic longint exp_count(input int r, input int n);
    return r - 1 - n;
  endfunction

  function automatic bit exp_warn_flag(input int r, input int w, input int n);
    return (r - 2 - n) < w;
  endfunction

  function automatic bit exp_irq(input int r, input int w, input int n);
    return (r - 2 - n) <= w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] c1, c2;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();

    // R1 reset state
    rdreg(3'h0, rd); check(rd == 0, "R1 mode", rd, 0);
    rdreg(3'h3, rd); check(rd == 255, "R1 count", rd, 255);
    rdreg(3'h1, rd); check(rd == 255, "R1 reload", rd, 255);
    rdreg(3'h4, rd); check(rd == 0, "R1 warn", rd, 0);
    rdreg(3'h5, rd); check(rd == 32'hFFFFFF, "R1 window", rd, 32'hFFFFFF);
    check(irq_o == 0 && sys_rst_req_o == 0, "R1 outputs", {irq_o, sys_rst_req_o}, 0);

    // R2 enable alone does not count; feed starts; cannot stop
    wr(3'h0, 32'h1);
    repeat (10) @(negedge clk);
    rdreg(3'h3, c1); rdreg(3'h3, c2);
    check(c1 == 255 && c2 == 255, "R2 idle before feed", c2, 255);
    wr(3'h1, 32'd1000);
    feed();
    rdreg(3'h3, rd); check(rd == 1000, "R3 feed reload", rd, 1000);
    wr(3'h0, 32'h0);
    rdreg(3'h0, rd); check(rd[0] == 1, "R2 enable sticky", rd[0], 1);
    rdreg(3'h3, c1); rdreg(3'h3, c2);
    check(c1 - c2 == 1, "R2 keeps counting", c1 - c2, 1);

    // R3 feed error, R6 clear polarity
    wr(3'h2, 32'hAA);
    wr(3'h4, 32'h0);
    rdreg(3'h0, rd); check(rd[2] == 1, "R3 feed error flag", rd[2], 1);
    rdreg(3'h3, rd); check(rd < 1000, "R3 no reload on error", rd, 999);
    wr(3'h0, 32'h5);
    rdreg(3'h0, rd); check(rd[2] == 1, "R6 write one keeps", rd[2], 1);
    wr(3'h0, 32'h1);
    rdreg(3'h0, rd); check(rd[2] == 0, "R6 write zero clears", rd[2], 0);
    feed();
    rdreg(3'h3, rd); check(rd == 1000, "R3 valid feed after error", rd, 1000);
    rdreg(3'h0, rd); check(rd[2] == 0, "R3 valid feed no flag", rd[2], 0);

    // R4 window
    do_reset();
    wr(3'h1, 32'd500); wr(3'h5, 32'd100); wr(3'h0, 32'h1);
    feed();
    repeat (3) @(negedge clk);
    feed();
    rdreg(3'h0, rd); check(rd[2] == 1, "R4 early feed flag", rd[2], 1);
    rdreg(3'h3, rd); check(rd < 500, "R4 early feed no reload", rd, 499);
    wr(3'h0, 32'h1);
    repeat (420) @(negedge clk);
    feed();
    rdreg(3'h3, rd); check(rd == 500, "R4 feed inside window", rd, 500);
    rdreg(3'h0, rd); check(rd[2] == 0, "R4 no flag inside window", rd[2], 0);

    // R5 expiry, interrupt mode; R8 blocked clear; R7 clear
    do_reset();
    wr(3'h1, 32'd30); wr(3'h0, 32'h1);
    feed();
    repeat (40) @(negedge clk);
    rdreg(3'h0, rd); check(rd[5:0] == 6'h0D, "R5 expiry flags", rd[5:0], 6'h0D);
    rdreg(3'h3, rd); check(rd == 0, "R5 count holds zero", rd, 0);
    check(irq_o == 1, "R9 irq in interrupt mode", irq_o, 1);
    check(rst_pulses == 0, "R9 no reset request", rst_pulses, 0);
    wr(3'h0, 32'h9);
    rdreg(3'h0, rd); check(rd[3] == 1, "R8 clear blocked at match", rd[3], 1);
    check(rd[2] == 0, "R6 cleared with bit2 zero", rd[2], 0);
    wr(3'h4, 32'd5);
    wr(3'h0, 32'h9);
    rdreg(3'h0, rd); check(rd[3] == 0, "R7 clear once unmatched", rd[3], 0);
    check(irq_o == 0, "R9 irq drops", irq_o, 0);

    // R9 reset mode
    do_reset();
    wr(3'h4, 32'd500); wr(3'h1, 32'd30); wr(3'h0, 32'h3);
    feed();
    repeat (40) @(negedge clk);
    check(rst_pulses == 1, "R9 single reset pulse", rst_pulses, 1);
    check(irq_o == 0, "R9 irq masks time-out", irq_o, 0);
    rdreg(3'h0, rd); check(rd[5:0] == 6'h07, "R9 flags", rd[5:0], 6'h07);
    wr(3'h0, 32'h1);
    rdreg(3'h0, rd); check(rd[5:0] == 6'h03, "R9 reset-enable sticky", rd[5:0], 6'h03);

    // R10 protect
    do_reset();
    wr(3'h1, 32'd200); wr(3'h4, 32'd50); wr(3'h5, 32'd100); wr(3'h0, 32'h11);
    feed();
    wr(3'h1, 32'd300);
    rdreg(3'h0, rd); check(rd[2] == 1, "R10 early reload flag", rd[2], 1);
    rdreg(3'h1, rd); check(rd == 200, "R10 reload kept", rd, 200);
    wr(3'h0, 32'h1);
    rdreg(3'h0, rd); check(rd[5:0] == 6'h11, "R10 protect sticky", rd[5:0], 6'h11);
    repeat (170) @(negedge clk);
    wr(3'h1, 32'd300);
    rdreg(3'h1, rd); check(rd == 300, "R10 late reload taken", rd, 300);
    rdreg(3'h0, rd); check(rd[2] == 0, "R10 late reload no flag", rd[2], 0);

    // R11 lock
    do_reset();
    clk_off_req_i = 1'b1; @(negedge clk);
    check(clk_off_grant_o == 1, "R11 grant follows", clk_off_grant_o, 1);
    wr(3'h0, 32'h21);
    @(negedge clk);
    check(clk_off_grant_o == 1, "R11 grant before feed", clk_off_grant_o, 1);
    feed();
    check(clk_off_grant_o == 0, "R11 grant held off", clk_off_grant_o, 0);
    clk_off_req_i = 1'b0; repeat (2) @(negedge clk);
    clk_off_req_i = 1'b1; repeat (2) @(negedge clk);
    check(clk_off_grant_o == 0, "R11 grant stays off", clk_off_grant_o, 0);
    wr(3'h0, 32'h0);
    rdreg(3'h0, rd); check(rd[5] == 1, "R11 lock sticky", rd[5], 1);
    clk_off_req_i = 1'b0;

    // random sweep across the threshold crossing (R2, R3, R7)
    for (int it = 0; it < 20; it++) begin
      int r, w, n;
      r = 60 + int'($urandom % 140);
      w = 10 + int'($urandom % (r - 40));
      n = int'($urandom % (r - 10));
      do_reset();
      wr(3'h1, r); wr(3'h4, w); wr(3'h0, 32'h1);
      feed();
      rdreg(3'h3, rd); check(rd == r, "R3 random reload", rd, r);
      repeat (n) @(negedge clk);
      rdreg(3'h3, rd); check(rd == exp_count(r, n), "R2 random count", rd, exp_count(r, n));
      rdreg(3'h0, rd);
      check(rd[3] == exp_warn_flag(r, w, n), "R7 random warn flag", rd[3], exp_warn_flag(r, w, n));
      check(irq_o == exp_irq(r, w, n), "R9 random irq", irq_o, exp_irq(r, w, n));
      if (exp_warn_flag(r, w, n)) begin
        wr(3'h0, 32'h1);
        rdreg(3'h0, rd); check(rd[3] == 1, "R7 write zero keeps", rd[3], 1);
        wr(3'h0, 32'h9);
        rdreg(3'h0, rd); check(rd[3] == 0, "R7 write one clears", rd[3], 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule